// File: doc/BRIEF.md
# Bit-Serial Toggle-Ripple Add/Subtract Accumulator

This block holds a multi-bit running value in which every bit is a toggle cell. A start strobe captures an operand word and an add/subtract select. The block then visits the operand bits one position at a time, lowest first. For every 1 bit it sends a toggle-with-carry request to the matching cell. A cell that flips in the "carrying" direction passes a toggle-with-carry request to the cell above it on the next clock. In add mode that direction is 1 to 0. In subtract mode it is 0 to 1. Carries and borrows therefore travel upward one cell per cycle.

After each position the block waits a settle interval, so that the ripple from one position is complete before the next position is touched. The interval is at least two delay units and never shorter than the longest possible ripple. A flag records the direction of the most recent transition of the top cell, which makes it the carry out of an add or the inverted borrow of a subtract. A one-cycle done pulse marks the end of the operation. Longer numbers are built by a sequencer outside the block, which issues several operations in turn.

Top module: `ripple_accumulator`

## Requirements
- R1: While reset (active-high, synchronous) is applied, and in the first cycle after it is released, `acc_value` is 0, `carry_flag` is 0 and `done` is 0.
- R2: When `sub_sel` is 0 at the start strobe, `acc_value` after the operation equals (previous value + `operand`) modulo 2^WIDTH.
- R3: When `sub_sel` is 1 at the start strobe, `acc_value` after the operation equals (previous value - `operand`) modulo 2^WIDTH.
- R4: In add mode, a toggle-with-carry that takes a cell from 1 to 0 sends a toggle request to the next cell in the following cycle. A cell that goes from 0 to 1 sends none.
- R5: In subtract mode, a toggle-with-carry that takes a cell from 0 to 1 sends a toggle request to the next cell in the following cycle. A cell that goes from 1 to 0 sends none.
- R6: `carry_flag` becomes 1 in the cycle after the top cell falls from 1 to 0, and becomes 0 in the cycle after it rises from 0 to 1. It keeps its value across an operation in which the top cell does not change.
- R7: `done` is a single-cycle pulse. It is high exactly 1 + WIDTH*(S+1) cycles after the cycle in which `start` was sampled, where S = max(2*UNIT_CYC, WIDTH+1).
- R8: A `start` that arrives while an operation is in progress is ignored. It changes neither the result nor the done timing, and it produces no further done pulse.
- R9: Operand bit k is applied in cycle 1 + k*(S+1) after the start cycle, so that `acc_value` shows its effect from cycle 2 + k*(S+1). A 0 operand bit leaves its cell untouched.
- R10: A carry or borrow out of the top cell is dropped from `acc_value` and appears only in `carry_flag`. For example, 0xFF + 1 gives 0x00 with the flag at 1, and 0x00 - 1 gives 0xFF with the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when the block is idle |
| operand | input | WIDTH | Word to add or subtract, captured at start |
| sub_sel | input | 1 | 0 selects add, 1 selects subtract, captured at start |
| acc_value | output | WIDTH | Current state of the toggle cells |
| carry_flag | output | 1 | Direction of the last transition of the top cell |
| done | output | 1 | One-cycle pulse at the end of an operation |

## Verification
With the default parameters the settle interval is 10 cycles. Each bit position therefore occupies 11 cycles, and `done` is due 89 cycles after the start cycle. The bench counts cycles from the start edge and samples on the falling clock edge. It expects `done` in exactly that cycle, and it expects the result and the flag there too. The flag is taken one cycle behind the top cell, which the settle margin already covers. Probe runs read `acc_value` one cycle before and one cycle after the application cycle of a chosen bit. Extra starts are driven at a known cycle in the middle of an operation, and the bench then watches a full further latency window for a stray `done` pulse.

// File: rtl/acc_pkg.sv
package acc_pkg;

    // Command accepted by one toggle cell in a cycle
    typedef enum logic [2:0] {
        CELL_HOLD = 3'd0,
        CELL_SET1 = 3'd1,
        CELL_SET0 = 3'd2,
        CELL_FLIP = 3'd3,
        CELL_TWC  = 3'd4
    } cell_cmd_e;

    // Registered transition events reported by a cell
    typedef struct packed {
        logic fell;
        logic rose;
    } cell_evt_t;

    // Sequencer phases
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_APPLY  = 2'd1,
        SQ_SETTLE = 2'd2,
        SQ_DONE   = 2'd3
    } seq_state_e;

    // Settle interval: two delay units, but never shorter than a full ripple
    function automatic int settle_cycles(input int unit_cyc, input int width);
        int two_units;
        two_units = 2 * unit_cyc;
        return (two_units > width + 1) ? two_units : width + 1;
    endfunction

    // Whether a toggle-with-carry on a cell holding cur passes a request upward
    function automatic logic passes_hop(input logic cur, input logic sub_mode);
        return sub_mode ? ~cur : cur;
    endfunction

endpackage

// File: rtl/ripple_cell.sv
module ripple_cell
    import acc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cell_cmd_e cmd,
    input  logic      sub_mode,
    output logic      q,
    output logic      hop_out,
    output cell_evt_t evt
);

    logic q_next;
    logic hop_next;

    always_comb begin
        q_next   = q;
        hop_next = 1'b0;
        unique case (cmd)
            CELL_SET1: q_next = 1'b1;
            CELL_SET0: q_next = 1'b0;
            CELL_FLIP: q_next = ~q;
            CELL_TWC: begin
                q_next   = ~q;
                hop_next = passes_hop(q, sub_mode);
            end
            default: q_next = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= 1'b0;
            hop_out  <= 1'b0;
            evt      <= '0;
        end else begin
            q        <= q_next;
            hop_out  <= hop_next;
            evt.fell <= q & ~q_next;
            evt.rose <= ~q & q_next;
        end
    end

    // R2: a toggle-with-carry always flips the cell
    a_r2_twc_flips: assert property (@(posedge clk) disable iff (rst)
        (cmd == CELL_TWC) |=> (q != $past(q)));

    // R4: add mode hop on 1 -> 0 only
    a_r4_add_hop: assert property (@(posedge clk) disable iff (rst)
        (cmd == CELL_TWC && !sub_mode && q) |=> hop_out);
    a_r4_add_no_hop: assert property (@(posedge clk) disable iff (rst)
        (cmd == CELL_TWC && !sub_mode && !q) |=> !hop_out);

    // R5: subtract mode hop on 0 -> 1 only
    a_r5_sub_hop: assert property (@(posedge clk) disable iff (rst)
        (cmd == CELL_TWC && sub_mode && !q) |=> hop_out);
    a_r5_sub_no_hop: assert property (@(posedge clk) disable iff (rst)
        (cmd == CELL_TWC && sub_mode && q) |=> !hop_out);

endmodule

// File: rtl/carry_tracker.sv
module carry_tracker
    import acc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cell_evt_t top_evt,
    output logic      flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (top_evt.fell) begin
            flag <= 1'b1;
        end else if (top_evt.rose) begin
            flag <= 1'b0;
        end
    end

    // R6: a cell cannot fall and rise in the same cycle
    a_r6_evt_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(top_evt.fell && top_evt.rose));

endmodule

// File: rtl/bit_sequencer.sv
module bit_sequencer
    import acc_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int SETTLE_CYC = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] operand_in,
    input  logic             sub_in,
    output logic [WIDTH-1:0] apply_vec,
    output logic             sub_mode,
    output logic             done
);

    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(WIDTH - 1);
    localparam logic [CNT_W-1:0] SETTLE_TOP = CNT_W'(SETTLE_CYC - 1);

    seq_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] cnt;
    logic [WIDTH-1:0] op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            idx      <= '0;
            cnt      <= '0;
            op_q     <= '0;
            sub_mode <= 1'b0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (start) begin
                        op_q     <= operand_in;
                        sub_mode <= sub_in;
                        idx      <= '0;
                        state    <= SQ_APPLY;
                    end
                end
                SQ_APPLY: begin
                    cnt   <= SETTLE_TOP;
                    state <= SQ_SETTLE;
                end
                SQ_SETTLE: begin
                    if (cnt == '0) begin
                        if (idx == LAST_IDX) begin
                            state <= SQ_DONE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= SQ_APPLY;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        apply_vec = '0;
        if (state == SQ_APPLY && op_q[idx]) begin
            apply_vec = WIDTH'(1) << idx;
        end
    end

    assign done = (state == SQ_DONE);

    // R7: done lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: at most one position is driven per cycle
    a_r9_one_position: assert property (@(posedge clk) disable iff (rst)
        $onehot0(apply_vec));

    // R8: mode and operand are frozen once an operation is under way
    a_r8_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        (state != SQ_IDLE) |=> ($stable(sub_mode) && $stable(op_q)));

    // R9: positions are visited in rising order
    a_r9_rising_order: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_APPLY && $past(state) == SQ_SETTLE) |-> (idx == $past(idx) + 1'b1));

endmodule

// File: rtl/ripple_accumulator.sv
module ripple_accumulator
    import acc_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int UNIT_CYC = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] operand,
    input  logic             sub_sel,
    output logic [WIDTH-1:0] acc_value,
    output logic             carry_flag,
    output logic             done
);

    localparam int SETTLE_CYC = settle_cycles(UNIT_CYC, WIDTH);

    logic [WIDTH-1:0] apply_vec;
    logic [WIDTH-1:0] hop;
    logic             sub_mode;
    cell_cmd_e        cmd    [WIDTH];
    cell_evt_t        evt    [WIDTH];

    bit_sequencer #(
        .WIDTH      (WIDTH),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .operand_in (operand),
        .sub_in     (sub_sel),
        .apply_vec  (apply_vec),
        .sub_mode   (sub_mode),
        .done       (done)
    );

    for (genvar k = 0; k < WIDTH; k++) begin : g_cell
        logic req;
        if (k == 0) begin : g_lsb
            assign req = apply_vec[k];
        end else begin : g_upper
            assign req = apply_vec[k] | hop[k-1];
        end
        assign cmd[k] = req ? CELL_TWC : CELL_HOLD;

        ripple_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .cmd      (cmd[k]),
            .sub_mode (sub_mode),
            .q        (acc_value[k]),
            .hop_out  (hop[k]),
            .evt      (evt[k])
        );
    end

    // hop[WIDTH-1] is the dropped carry out of the top cell
    carry_tracker u_flag (
        .clk     (clk),
        .rst     (rst),
        .top_evt (evt[WIDTH-1]),
        .flag    (carry_flag)
    );

    // R6: the flag follows the top cell direction one cycle later
    a_r6_flag_set: assert property (@(posedge clk) disable iff (rst)
        $fell(acc_value[WIDTH-1]) |=> carry_flag);
    a_r6_flag_clear: assert property (@(posedge clk) disable iff (rst)
        $rose(acc_value[WIDTH-1]) |=> !carry_flag);

    // R10: the ripple has died out by the time done is shown
    a_r10_quiet_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> (hop == '0));

endmodule

// File: tb/sim_ripple_accumulator.sv
module sim_ripple_accumulator;

    localparam int W        = 8;
    localparam int UNIT     = 5;
    localparam int CLK_PER  = 10;
    localparam int S        = (2 * UNIT > W + 1) ? 2 * UNIT : W + 1;
    localparam int LAT      = 1 + W * (S + 1);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] operand = '0;
    logic         sub_sel = 1'b0;
    logic [W-1:0] acc_value;
    logic         carry_flag;
    logic         done;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    logic [W-1:0] exp_acc  = '0;
    logic         exp_flag = 1'b0;

    ripple_accumulator #(.WIDTH(W), .UNIT_CYC(UNIT)) u0 (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .operand    (operand),
        .sub_sel    (sub_sel),
        .acc_value  (acc_value),
        .carry_flag (carry_flag),
        .done       (done)
    );

    always #(CLK_PER / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Bit-serial toggle model: returns {flag, value}
    function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] op,
                                         input bit sub, input logic flag);
        logic [W-1:0] v = a;
        logic         f = flag;
        for (int k = 0; k < W; k++) begin
            if (op[k]) begin
                int  j  = k;
                bit  go = 1;
                while (go) begin
                    logic old = v[j];
                    v[j] = ~old;
                    if (j == W - 1) f = old;
                    go = (sub ? !old : old) && (j < W - 1);
                    j++;
                end
            end
        end
        return {f, v};
    endfunction

    // probe_k >= 0: check R9 timing of that bit; intrude: extra start mid-run
    task automatic run_op(input logic [W-1:0] opv, input bit sub, input int probe_k,
                          input bit intrude);
        logic [W:0]   m;
        logic [W-1:0] arith;
        logic [W-1:0] old = exp_acc;
        int n;
        m = model(exp_acc, opv, sub, exp_flag);
        arith = sub ? (exp_acc - opv) : (exp_acc + opv);
        chk(m[W-1:0] == arith, sub ? "R3 model" : "R2 model", int'(m[W-1:0]), int'(arith));
        @(negedge clk);
        start = 1'b1; operand = opv; sub_sel = sub;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < LAT + 20) begin
            if (probe_k >= 0 && n == 1 + probe_k * (S + 1))
                chk(acc_value == old, "R9 before apply", int'(acc_value), int'(old));
            if (probe_k >= 0 && n == 2 + probe_k * (S + 1))
                chk(acc_value == (old ^ (W'(1) << probe_k)), "R9 after apply",
                    int'(acc_value), int'(old ^ (W'(1) << probe_k)));
            if (intrude && n == 20) begin
                start = 1'b1; operand = ~opv; sub_sel = ~sub;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(done && n == LAT, "R7 done latency", n, LAT);
        exp_acc  = arith;
        exp_flag = m[W];
        chk(acc_value == exp_acc, sub ? "R3 result" : "R2 result", int'(acc_value), int'(exp_acc));
        chk(carry_flag == exp_flag, "R6 flag", int'(carry_flag), int'(exp_flag));
        @(negedge clk);
        chk(!done, "R7 done one cycle", int'(done), 0);
        if (intrude) begin
            bit extra = 0;
            for (int i = 0; i < LAT + 5; i++) begin
                if (done) extra = 1;
                @(negedge clk);
            end
            chk(!extra, "R8 no second done", int'(extra), 0);
            chk(acc_value == exp_acc, "R8 value kept", int'(acc_value), int'(exp_acc));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        chk(acc_value == '0 && carry_flag == 1'b0 && done == 1'b0, "R1 during reset",
            int'({carry_flag, done, acc_value}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(acc_value == '0 && carry_flag == 1'b0 && done == 1'b0, "R1 after reset",
            int'({carry_flag, done, acc_value}), 0);

        // R9: single-bit operands with no ripple, timing probed
        run_op(8'h01, 1'b0, 0, 1'b0);
        run_op(8'h20, 1'b0, 5, 1'b0);
        run_op(8'h80, 1'b0, 7, 1'b0);   // top rises: flag 0
        // R6: top unchanged keeps flag; reach 0xFF
        run_op(8'h5E, 1'b0, -1, 1'b0);
        // R10: carry and borrow out of the top
        run_op(8'h01, 1'b0, -1, 1'b0);
        chk(acc_value == 8'h00 && carry_flag, "R10 add wrap", int'({carry_flag, acc_value}), 9'h100);
        run_op(8'h01, 1'b1, -1, 1'b0);
        chk(acc_value == 8'hFF && !carry_flag, "R10 sub wrap", int'({carry_flag, acc_value}), 9'h0FF);
        // R4: long add ripple, R5: long subtract ripple
        run_op(8'h01, 1'b0, -1, 1'b0);
        run_op(8'h01, 1'b1, -1, 1'b0);
        // R8: start while busy
        run_op(8'h10, 1'b0, -1, 1'b1);
        run_op(8'h33, 1'b1, -1, 1'b1);
        // zero operand changes nothing (R9)
        run_op(8'h00, 1'b1, -1, 1'b0);
        // random mix for R2, R3, R6
        for (int i = 0; i < 24; i++) begin
            logic [W-1:0] r = W'($urandom);
            bit s = bit'($urandom % 2);
            run_op(r, s, -1, 1'b0);
        end
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule